// File: doc/BRIEF.md
# March-Sequence Memory Self-Test Controller

This controller checks a synchronous single-port SRAM by sweeping it with a fixed March sequence. The sequence is a short ordered list of elements. Each element names a sweep direction and up to four memory operations. Every operation is either a write or a read-and-compare, and it carries a single data bit that is widened to a full word of zeros or ones. The controller applies all of an element's operations to one address, steps to the next address in the element's direction, and moves on to the next element once the last address is done. It issues exactly one memory access per clock while the test runs.

Each read is checked one clock after it is issued, because the SRAM returns data with one cycle of latency. On the first word that differs from the expected pattern, the controller raises `fail` and records the address, the element index and the operation index. It then finishes the sweep, pulses `done` for a single cycle, and waits for the next `start`.

The sequencer is a four-state machine. IDLE moves to RUN on an accepted `start` (transition GO). RUN moves to DRAIN after the last operation of the last element (transition FINISH). DRAIN moves to REPORT after one cycle, which lets the final read be compared (transition SETTLE). REPORT moves back to IDLE after one cycle (transition RETIRE).

Top module: `march_bist`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `fail`, `mem_req` and `mem_we` are 0, and `fail_addr`, `fail_elem` and `fail_op` are 0.
- R2: `start` is acted on only in IDLE. A `start` raised during a test does not change the access trace and does not shorten the test.
- R3: One test issues exactly 6·N memory accesses (N = 2^ADDR_W), with `mem_req` high in consecutive cycles and low otherwise.
- R4: The element sequence has three elements, with operations indexed from 0. Element 0 is write 0. Element 1 runs ascending and does read 0, then write 1. Element 2 runs descending (N-1 down to 0) and does read 1, write 0, read 0. All operations of an element reach one address before the address changes. `mem_we` is 1 for writes and 0 for reads.
- R5: A write drives `mem_wdata` with all bits equal to the operation's data bit.
- R6: A read's data is compared in the cycle after the read is issued. If it is not all-equal to the expected bit, `fail` is set.
- R7: Only the first mismatch of a test is recorded in `fail_addr`, `fail_elem` and `fail_op`. Later mismatches leave them unchanged.
- R8: `done` is high for exactly one cycle, 6·N+2 cycles after the cycle in which `start` is accepted. `fail` and the capture fields are final at that point and hold until the next accepted `start`.
- R9: An accepted `start` clears `fail` and all three capture fields to 0.
- R10: An element whose direction is "either" (element 0) sweeps in ascending order, from 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test; acted on in IDLE only |
| done | output | 1 | One-cycle pulse when the test has completed |
| fail | output | 1 | At least one read mismatched in this test |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 2 | Element index of the first mismatch |
| fail_op | output | 2 | Operation index within the element of the first mismatch |
| mem_req | output | 1 | Memory access this cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | 1 = write, 0 = read (valid with mem_req) |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
After `start` is accepted, the first access appears in the next cycle. The bench then walks its own model of the sequence, one access per cycle, and compares address, write enable and data at each falling edge. `done` is due two cycles after the last access: one cycle for the compare register and one for the report state. The bench therefore samples `mem_req` low in the DRAIN cycle, and it samples `done`, `fail` and the capture fields in the REPORT cycle, which is 6·N+2 cycles after the start. Faults are injected into the memory model only. The expected failing address, element and operation come from where the descending read-1 pass first meets the broken bit.

// File: rtl/march_pkg.sv
package march_pkg;

    localparam int MAX_OPS   = 4;
    localparam int NUM_ELEMS = 3;
    localparam int ELEM_W    = 2;
    localparam int OPS_W     = 2;
    localparam int NOPS_W    = 3;

    typedef enum logic [1:0] {
        DIR_UP   = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_ANY  = 2'd2
    } dir_e;

    typedef struct packed {
        logic wr;
        logic val;
    } mop_t;

    typedef struct packed {
        dir_e                    dir;
        logic [NOPS_W-1:0]       nops;
        mop_t [MAX_OPS-1:0]      ops;
    } elem_t;

    // Constant element table: {w0} ; up{r0,w1} ; down{r1,w0,r0}
    function automatic elem_t elem_at(input logic [ELEM_W-1:0] idx);
        elem_t e;
        e = '0;
        unique case (idx)
            2'd0: begin
                e.dir    = DIR_ANY;
                e.nops   = 3'd1;
                e.ops[0] = '{wr: 1'b1, val: 1'b0};
            end
            2'd1: begin
                e.dir    = DIR_UP;
                e.nops   = 3'd2;
                e.ops[0] = '{wr: 1'b0, val: 1'b0};
                e.ops[1] = '{wr: 1'b1, val: 1'b1};
            end
            2'd2: begin
                e.dir    = DIR_DOWN;
                e.nops   = 3'd3;
                e.ops[0] = '{wr: 1'b0, val: 1'b1};
                e.ops[1] = '{wr: 1'b1, val: 1'b0};
                e.ops[2] = '{wr: 1'b0, val: 1'b0};
            end
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic int total_ops();
        int s;
        s = 0;
        for (int i = 0; i < NUM_ELEMS; i++) begin
            s += int'(elem_at(ELEM_W'(i)).nops);
        end
        return s;
    endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
    import march_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              issue,
    output logic              op_wr,
    output logic              op_val,
    output logic [ADDR_W-1:0] addr,
    output logic [ELEM_W-1:0] elem,
    output logic [OPS_W-1:0]  op,
    output logic              clr,
    output logic              done
);

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_DRAIN  = 2'd2,
        S_REPORT = 2'd3
    } state_e;

    state_e state_q, state_d;

    elem_t cur;
    logic  last_op, last_addr, last_elem, ascend;

    function automatic logic [ADDR_W-1:0] first_addr(input logic [ELEM_W-1:0] idx);
        return (elem_at(idx).dir == DIR_DOWN) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
    endfunction

    always_comb begin
        cur       = elem_at(elem);
        ascend    = (cur.dir != DIR_DOWN);
        last_op   = ({1'b0, op} == (cur.nops - 3'd1));
        last_addr = ascend ? (addr == {ADDR_W{1'b1}}) : (addr == {ADDR_W{1'b0}});
        last_elem = (elem == ELEM_W'(NUM_ELEMS - 1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_RUN;
            S_RUN:    if (last_op && last_addr && last_elem) state_d = S_DRAIN;
            S_DRAIN:  state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // sweep position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem <= '0;
            op   <= '0;
            addr <= '0;
        end else if (state_q == S_IDLE && start) begin
            elem <= '0;
            op   <= '0;
            addr <= first_addr('0);
        end else if (state_q == S_RUN) begin
            if (!last_op) begin
                op <= op + OPS_W'(1);
            end else begin
                op <= '0;
                if (!last_addr) begin
                    addr <= ascend ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
                end else if (!last_elem) begin
                    elem <= elem + ELEM_W'(1);
                    addr <= first_addr(elem + ELEM_W'(1));
                end
            end
        end
    end

    // outputs
    always_comb begin
        issue  = 1'b0;
        op_wr  = 1'b0;
        op_val = cur.ops[op].val;
        clr    = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            S_IDLE:   clr = start;
            S_RUN: begin
                issue = 1'b1;
                op_wr = cur.ops[op].wr;
            end
            S_DRAIN:  ;
            S_REPORT: done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/march_cmp.sv
module march_cmp
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              issue,
    input  logic              op_wr,
    input  logic              op_val,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ELEM_W-1:0] elem,
    input  logic [OPS_W-1:0]  op,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic [OPS_W-1:0]  fail_op
);

    logic              pend_v, pend_val;
    logic [ADDR_W-1:0] pend_addr;
    logic [ELEM_W-1:0] pend_elem;
    logic [OPS_W-1:0]  pend_op;
    logic              mismatch;

    // read in flight: compared one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_val  <= 1'b0;
            pend_addr <= '0;
            pend_elem <= '0;
            pend_op   <= '0;
        end else begin
            pend_v    <= issue && !op_wr;
            pend_val  <= op_val;
            pend_addr <= addr;
            pend_elem <= elem;
            pend_op   <= op;
        end
    end

    assign mismatch = pend_v && (rdata != {DATA_W{pend_val}});

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_op   <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
            fail_elem <= pend_elem;
            fail_op   <= pend_op;
        end
    end

endmodule

// File: rtl/march_bist.sv
module march_bist
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic [OPS_W-1:0]  fail_op,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              op_val, clr;
    logic [ELEM_W-1:0] cur_elem;
    logic [OPS_W-1:0]  cur_op;

    march_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .issue  (mem_req),
        .op_wr  (mem_we),
        .op_val (op_val),
        .addr   (mem_addr),
        .elem   (cur_elem),
        .op     (cur_op),
        .clr    (clr),
        .done   (done)
    );

    assign mem_wdata = {DATA_W{op_val}};

    march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .issue     (mem_req),
        .op_wr     (mem_we),
        .op_val    (op_val),
        .addr      (mem_addr),
        .elem      (cur_elem),
        .op        (cur_op),
        .rdata     (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem),
        .fail_op   (fail_op)
    );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [ELEM_W-1:0] fail_elem,
    input logic [OPS_W-1:0]  fail_op,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);

    localparam int EXPECTED = total_ops() * (1 << ADDR_W);

    int req_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || done) req_cnt <= 0;
        else if (mem_req)   req_cnt <= req_cnt + 1;
    end

    a_r3_access_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_cnt == EXPECTED);

    a_r3_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    a_r5_word_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == {DATA_W{1'b0}} || mem_wdata == {DATA_W{1'b1}}));

    a_r4_addr_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |->
            (mem_addr == $past(mem_addr)) ||
            (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))) ||
            (mem_addr == ADDR_W'($past(mem_addr) - ADDR_W'(1))));

    a_r6_fail_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(mem_req && !mem_we, 2));

    a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fail && $past(fail) |->
            $stable(fail_addr) && $stable(fail_elem) && $stable(fail_op));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .fail_op   (fail_op),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/sram_model.sv
module sram_model #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sa_en,
    input  logic [ADDR_W-1:0] sa_addr,
    input  int                sa_bit,
    input  logic              tf_en,
    input  logic [ADDR_W-1:0] tf_addr,
    input  int                tf_bit
);

    logic [DATA_W-1:0] mem [1 << ADDR_W];
    logic [DATA_W-1:0] next_word, sa_mask;

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = DATA_W'(8'hA5 ^ i);
        rdata = '0;
    end

    always_comb begin
        next_word = wdata;
        if (tf_en && addr == tf_addr && !mem[addr][tf_bit] && wdata[tf_bit])
            next_word[tf_bit] = 1'b0;
        sa_mask = (sa_en && addr == sa_addr) ? (DATA_W'(1) << sa_bit) : '0;
    end

    always @(posedge clk) begin
        if (req) begin
            if (we) mem[addr] <= next_word;
            else    rdata     <= mem[addr] & ~sa_mask;
        end
    end

endmodule

// File: tb/tb_march_bist.sv
module tb_march_bist;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int N      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n, start;
    logic              done, fail, mem_req, mem_we;
    logic [ADDR_W-1:0] fail_addr, mem_addr;
    logic [1:0]        fail_elem, fail_op;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              sa_en, tf_en;
    logic [ADDR_W-1:0] sa_addr, tf_addr;
    int                sa_bit, tf_bit;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    march_bist #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk, .rst_n, .start, .done, .fail, .fail_addr, .fail_elem, .fail_op,
        .mem_req, .mem_addr, .mem_we, .mem_wdata, .mem_rdata
    );

    sram_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(mem_rdata), .sa_en(sa_en), .sa_addr(sa_addr), .sa_bit(sa_bit),
        .tf_en(tf_en), .tf_addr(tf_addr), .tf_bit(tf_bit)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int nops(input int e);
        return e + 1;
    endfunction
    function automatic bit op_is_wr(input int e, input int o);
        return (e == 0) || (e == 1 && o == 1) || (e == 2 && o == 1);
    endfunction
    function automatic bit op_bit(input int e, input int o);
        return (e == 1 && o == 1) || (e == 2 && o == 0);
    endfunction

    task automatic run_march(input bit exp_fail, input int exp_addr, input int exp_elem,
                             input int exp_op, input bit poke_start);
        bit first = 1;
        int k = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(fail == 1'b0 && fail_addr == '0 && fail_elem == '0 && fail_op == '0,
              "R9", "capture cleared on start", {fail, fail_addr}, 0);
        for (int e = 0; e < 3; e++) begin
            for (int i = 0; i < N; i++) begin
                int a;
                a = (e == 2) ? (N - 1 - i) : i;
                for (int o = 0; o < nops(e); o++) begin
                    if (!first) @(negedge clk);
                    first = 0;
                    start = poke_start && (k == 20);
                    check(mem_req == 1'b1 && int'(mem_addr) == a,
                          (e == 0) ? "R10" : "R4", "request/address", {mem_req, mem_addr}, {1'b1, a[ADDR_W-1:0]});
                    check(mem_we == op_is_wr(e, o), "R4", "op type", mem_we, op_is_wr(e, o));
                    if (op_is_wr(e, o))
                        check(mem_wdata == {DATA_W{op_bit(e, o)}}, "R5", "write word",
                              mem_wdata, {DATA_W{op_bit(e, o)}});
                    k++;
                end
            end
        end
        start = 1'b0;
        @(negedge clk);
        check(mem_req == 1'b0 && done == 1'b0, "R3", "no access after 6N", {mem_req, done}, 0);
        @(negedge clk);
        check(done == 1'b1, "R8", "done at 6N+2", done, 1);
        check(fail == exp_fail, "R6", "fail flag", fail, exp_fail);
        if (exp_fail) begin
            check(int'(fail_addr) == exp_addr, "R7", "fail_addr", fail_addr, exp_addr);
            check(int'(fail_elem) == exp_elem, "R7", "fail_elem", fail_elem, exp_elem);
            check(int'(fail_op) == exp_op, "R7", "fail_op", fail_op, exp_op);
        end
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", done, 0);
        check(fail == exp_fail, "R8", "fail held", fail, exp_fail);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 0 && fail == 0 && mem_req == 0 && mem_we == 0, "R1", "outputs in reset",
              {done, fail, mem_req, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fail_addr == '0 && fail_elem == '0 && fail_op == '0 && mem_req == 0, "R1",
              "captures after reset", {fail_addr, fail_elem, fail_op}, 0);
    endtask

    task automatic test_clean();
        sa_en = 0; tf_en = 0;
        run_march(1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic test_start_ignored();
        sa_en = 0; tf_en = 0;
        run_march(1'b0, 0, 0, 0, 1'b1);   // R2: mid-run start leaves trace intact
        repeat (3) @(negedge clk);
        check(mem_req == 1'b0, "R2", "no restart after ignored start", mem_req, 0);
    endtask

    task automatic test_stuck_at0();
        sa_en = 1; sa_addr = 4'd5; sa_bit = 3; tf_en = 0;
        run_march(1'b1, 5, 2, 0, 1'b0);
        sa_en = 0;
    endtask

    task automatic test_transition();
        tf_en = 1; tf_addr = 4'd12; tf_bit = 0; sa_en = 0;
        run_march(1'b1, 12, 2, 0, 1'b0);
        tf_en = 0;
    endtask

    task automatic test_first_only();
        sa_en = 1; sa_addr = 4'd5; sa_bit = 3;
        tf_en = 1; tf_addr = 4'd9; tf_bit = 6;
        run_march(1'b1, 9, 2, 0, 1'b0);     // R7: descending pass meets address 9 first
        sa_en = 0; tf_en = 0;
    endtask

    initial begin
        start = 0; sa_en = 0; tf_en = 0;
        sa_addr = '0; tf_addr = '0; sa_bit = 0; tf_bit = 0;
        rst_n = 0;
        test_reset();
        test_clean();
        test_stuck_at0();
        test_start_ignored();
        test_transition();
        test_first_only();
        test_clean();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule